// File: doc/BRIEF.md
# Oscillator Clock Switch Controller

This block sequences a change of the system clock from one oscillator source to another. Software picks a target through a 3-bit request field and then sets a switch-enable flag. The controller first weighs the request against the source already in use. It drops redundant and forbidden requests at once. A valid request powers up the oscillators the target needs and waits for crystal start-up and PLL lock where these apply. It then counts ten edges of the new clock, and only after that does it move the clock-mux select and the current-source status.

The analog oscillators, the PLL and the glitch-free clock multiplexer sit outside this block. Each oscillator is represented by an enable output. Its readiness comes back through a start-up-timer-done input and a PLL-lock input, and both are synchronized inside the block. The edges of each source's clock arrive as single-cycle tick pulses in the controller's own clock domain, one tick line per source code. The switch-enable flag stays set for as long as a switch is pending. Software polls it: a cleared flag means the switch finished, and a flag that stays set with lock status low points to a PLL that never locked.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After reset, the current source and the mux select are 0 (fast RC), switch-enable, lock status and clock-fail status are 0, and only the fast-RC enable (osc_en bit 0) plus any bits kept by keep_lprc or keep_sec are high.
- R2: A request for the source already in use clears switch-enable on the second clock edge after the request pulse. It changes no current source, mux select, oscillator enable, lock or fail status.
- R3: Source codes are 0 fast RC, 1 fast RC with PLL, 2 primary crystal, 3 primary crystal with PLL, 4 secondary crystal, 5 low-power RC. The block rejects codes 6 and 7 and any direct move between codes 1 and 3 in either direction, in the same way as R2.
- R4: A valid switch clears lock status and clock-fail status on the second clock edge after the request pulse.
- R5: While a valid switch is pending, the enables the target needs are high. A crystal target (codes 2, 3, 4) does not advance until the start-up-timer-done input has been seen high.
- R6: A PLL target (codes 1, 3) does not advance until PLL lock has been seen. Lock status stays 0 until then and reads 1 once lock is seen while the PLL is enabled.
- R7: After the target is ready, the switch commits on exactly the tenth tick of the target source. Ticks of other sources, and ticks that arrive before readiness, are not counted.
- R8: On commit, the current source and mux select take the target code on the same edge that clears switch-enable.
- R9: After commit, osc_en holds only the bits the new source needs. The bits are 0 fast RC, 1 primary, 2 secondary, 3 low-power RC and 4 PLL. Bit 3 stays high while keep_lprc is high, and bit 2 stays high while keep_sec is high.
- R10: A switch-enable pulse that arrives while a switch is pending has no effect on the target.
- R11: If start-up or lock never arrives, switch-enable stays set and the current source stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_src | input | 3 | Requested source code, sampled with sw_en_set |
| sw_en_set | input | 1 | Software write that sets switch-enable |
| ost_done | input | 1 | Crystal start-up timer expired (asynchronous) |
| pll_lock | input | 1 | PLL locked (asynchronous) |
| src_tick | input | 6 | One-cycle edge pulse per source code |
| keep_lprc | input | 1 | Watchdog or clock monitor needs the low-power RC |
| keep_sec | input | 1 | Secondary oscillator kept enabled by software |
| fail_evt | input | 1 | Clock-fail event from the clock monitor |
| cur_src | output | 3 | Current source status |
| sw_en | output | 1 | Switch-enable flag, high while a switch is pending |
| osc_en | output | 5 | Oscillator enables (FRC, primary, secondary, LPRC, PLL) |
| mux_sel | output | 3 | Clock multiplexer select |
| lock_st | output | 1 | PLL lock status |
| fail_st | output | 1 | Clock-fail status |

## Verification
The bench drives every input on the falling edge and reads results on the next falling edge, so each result is compared exactly one half period after the rising edge that produces it. Switch-enable rises one edge after the request pulse. A reject clears it, or a valid start clears the status bits, on the second edge. Start-up and lock take two synchronizer edges plus one state edge before the block advances. The commit lands on the same edge that samples the tenth tick, so the bench checks the old source after the ninth tick and the new one after the tenth. A sweep over every source pair and every request code, with crystal and PLL readiness held high, applies this fixed schedule. Directed stalls then hold readiness low for a while to check waiting and pulses that are ignored.

// File: rtl/clksw_pkg.sv
// Package: shared source codes, oscillator bit positions, FSM states and
// decode helpers for the oscillator clock switch controller.
// Assumes a fixed 3-bit source code; codes at or above SRC_N are invalid.
package clksw_pkg;

    localparam int SRC_W = 3;
    localparam int SRC_N = 6;
    localparam int SRC_CODES = 1 << SRC_W;
    localparam int OSC_N = 5;

    localparam logic [SRC_W-1:0] SRC_FRC     = 3'd0;
    localparam logic [SRC_W-1:0] SRC_FRC_PLL = 3'd1;
    localparam logic [SRC_W-1:0] SRC_PRI     = 3'd2;
    localparam logic [SRC_W-1:0] SRC_PRI_PLL = 3'd3;
    localparam logic [SRC_W-1:0] SRC_SEC     = 3'd4;
    localparam logic [SRC_W-1:0] SRC_LPRC    = 3'd5;

    localparam int OSC_FRC  = 0;
    localparam int OSC_PRI  = 1;
    localparam int OSC_SEC  = 2;
    localparam int OSC_LPRC = 3;
    localparam int OSC_PLL  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_WAIT_OST,
        ST_WAIT_PLL,
        ST_COUNT
    } sw_state_t;

    // True when the code names a real source.
    function automatic logic src_valid(input logic [SRC_W-1:0] s);
        return int'(s) < SRC_N;
    endfunction

    // True when the source is driven through the PLL.
    function automatic logic src_uses_pll(input logic [SRC_W-1:0] s);
        return (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
    endfunction

    // True when the source relies on a crystal start-up timer.
    function automatic logic src_is_xtal(input logic [SRC_W-1:0] s);
        return (s == SRC_PRI) || (s == SRC_PRI_PLL) || (s == SRC_SEC);
    endfunction

    // Oscillators that must run for a given source.
    function automatic logic [OSC_N-1:0] src_osc_mask(input logic [SRC_W-1:0] s);
        logic [OSC_N-1:0] m;
        m = '0;
        case (s)
            SRC_FRC:     m[OSC_FRC] = 1'b1;
            SRC_FRC_PLL: begin m[OSC_FRC] = 1'b1; m[OSC_PLL] = 1'b1; end
            SRC_PRI:     m[OSC_PRI] = 1'b1;
            SRC_PRI_PLL: begin m[OSC_PRI] = 1'b1; m[OSC_PLL] = 1'b1; end
            SRC_SEC:     m[OSC_SEC] = 1'b1;
            SRC_LPRC:    m[OSC_LPRC] = 1'b1;
            default:     m = '0;
        endcase
        return m;
    endfunction

    // Legal transition check: valid target and no direct PLL-to-PLL hop.
    function automatic logic pair_allowed(input logic [SRC_W-1:0] from_s,
                                          input logic [SRC_W-1:0] to_s);
        if (!src_valid(to_s)) return 1'b0;
        if (src_uses_pll(from_s) && src_uses_pll(to_s) && (from_s != to_s)) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/clksw_sync.sv
// Module: multi-bit, multi-stage synchronizer for independent asynchronous
// level inputs. Assumes each bit is a slow level; no bus coherency.
module clksw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Shift through further flops to settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksw_edge_cnt.sv
// Module: counts tick pulses while enabled and flags the tick that reaches
// the target count. Assumes the owner clears it after done is seen.
module clksw_edge_cnt #(
    parameter int EDGES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(EDGES + 1);

    logic [CW-1:0] cnt_q;

    // Done on the tick that would make the count reach EDGES.
    assign done = tick && !clear && (cnt_q == CW'(EDGES - 1));

    // Count ticks of the selected clock, restarting while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end

    // R7: the counter never runs past the commit count.
    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(EDGES));
endmodule

// File: rtl/clksw_osc_en.sv
// Module: builds the oscillator enable vector from the current source, the
// pending target and the keep-running requests. Purely combinational.
module clksw_osc_en
    import clksw_pkg::*;
(
    input  logic [SRC_W-1:0] cur_src,
    input  logic [SRC_W-1:0] tgt_src,
    input  logic             pending,
    input  logic             keep_lprc,
    input  logic             keep_sec,
    output logic [OSC_N-1:0] osc_en
);
    // Union of what the current and pending sources need, plus kept ones.
    always_comb begin
        osc_en = src_osc_mask(cur_src);
        if (pending)   osc_en = osc_en | src_osc_mask(tgt_src);
        if (keep_lprc) osc_en[OSC_LPRC] = 1'b1;
        if (keep_sec)  osc_en[OSC_SEC]  = 1'b1;
    end
endmodule

// File: rtl/clk_switch_ctrl.sv
// Module: top of the oscillator clock switch controller. Accepts a switch
// request, rejects redundant or forbidden ones, waits for crystal start-up
// and PLL lock, counts EDGE_COUNT ticks of the new clock, then commits.
// Assumes src_tick pulses are one cycle wide in the clk domain and that
// ost_done and pll_lock are asynchronous levels.
module clk_switch_ctrl
    import clksw_pkg::*;
#(
    parameter int EDGE_COUNT  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] req_src,
    input  logic             sw_en_set,
    input  logic             ost_done,
    input  logic             pll_lock,
    input  logic [SRC_N-1:0] src_tick,
    input  logic             keep_lprc,
    input  logic             keep_sec,
    input  logic             fail_evt,
    output logic [SRC_W-1:0] cur_src,
    output logic             sw_en,
    output logic [OSC_N-1:0] osc_en,
    output logic [SRC_W-1:0] mux_sel,
    output logic             lock_st,
    output logic             fail_st
);
    sw_state_t        state_q;
    logic [SRC_W-1:0] cur_q, tgt_q, mux_q;
    logic             sw_en_q, lock_q, fail_q;
    logic             ost_s, lock_s;
    logic             pending, reject, start, commit, cnt_done, tgt_tick;
    logic [SRC_CODES-1:0] tick_ext;

    clksw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pll_lock, ost_done}),
        .q     ({lock_s, ost_s})
    );

    // Decode of the evaluated request and the commit condition.
    always_comb begin
        pending  = (state_q == ST_WAIT_OST) || (state_q == ST_WAIT_PLL) || (state_q == ST_COUNT);
        reject   = (tgt_q == cur_q) || !pair_allowed(cur_q, tgt_q);
        start    = (state_q == ST_EVAL) && !reject;
        tick_ext = {{(SRC_CODES - SRC_N){1'b0}}, src_tick};
        tgt_tick = tick_ext[tgt_q];
        commit   = (state_q == ST_COUNT) && cnt_done;
    end

    clksw_edge_cnt #(.EDGES(EDGE_COUNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_COUNT),
        .tick  (tgt_tick),
        .done  (cnt_done)
    );

    clksw_osc_en u_osc (
        .cur_src   (cur_q),
        .tgt_src   (tgt_q),
        .pending   (pending),
        .keep_lprc (keep_lprc),
        .keep_sec  (keep_sec),
        .osc_en    (osc_en)
    );

    // Switch sequencer: evaluate, wait for readiness, count, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= SRC_FRC;
            mux_q   <= SRC_FRC;
            tgt_q   <= SRC_FRC;
            sw_en_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (sw_en_set) begin
                        tgt_q   <= req_src;
                        sw_en_q <= 1'b1;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (reject) begin
                        sw_en_q <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_WAIT_OST;
                    end
                end
                ST_WAIT_OST: begin
                    if (!src_is_xtal(tgt_q) || ost_s) state_q <= ST_WAIT_PLL;
                end
                ST_WAIT_PLL: begin
                    if (!src_uses_pll(tgt_q) || lock_s) state_q <= ST_COUNT;
                end
                ST_COUNT: begin
                    if (cnt_done) begin
                        cur_q   <= tgt_q;
                        mux_q   <= tgt_q;
                        sw_en_q <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status bits: cleared on a valid start, then set by lock or fail events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (start)                            lock_q <= 1'b0;
            else if (lock_s && osc_en[OSC_PLL])   lock_q <= 1'b1;
            if (fail_evt)                         fail_q <= 1'b1;
            else if (start)                       fail_q <= 1'b0;
        end
    end

    assign cur_src = cur_q;
    assign mux_sel = mux_q;
    assign sw_en   = sw_en_q;
    assign lock_st = lock_q;
    assign fail_st = fail_q;

    // R2, R3: a rejected request leaves the source untouched and drops the flag.
    a_r2_reject_keeps_source: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && reject) |=> (!sw_en_q && $stable(cur_q) && $stable(mux_q)));

    // R4: a valid start leaves lock and fail status low.
    a_r4_start_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !fail_evt) |=> (!lock_q && !fail_q));

    // R6: a PLL source is only committed once lock status is high.
    a_r6_pll_locked_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && src_uses_pll(tgt_q)) |-> lock_q);

    // R8: the current source only moves on the edge that clears switch-enable.
    a_r8_cur_moves_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> (!sw_en_q && $past(sw_en_q) && (mux_q == cur_q)));

    // R9: everything the current source needs stays enabled.
    a_r9_current_running: assert property (@(posedge clk) disable iff (!rst_n)
        ((osc_en & src_osc_mask(cur_q)) == src_osc_mask(cur_q)));

    // R10: the target is frozen while a switch is pending.
    a_r10_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(tgt_q));
endmodule

// File: tb/clk_switch_ctrl_tb.sv
module clk_switch_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_src = 3'd0;
    logic       sw_en_set = 1'b0;
    logic       ost_done = 1'b1;
    logic       pll_lock = 1'b1;
    logic [5:0] src_tick = 6'd0;
    logic       keep_lprc = 1'b0;
    logic       keep_sec = 1'b0;
    logic       fail_evt = 1'b0;
    logic [2:0] cur_src;
    logic       sw_en;
    logic [4:0] osc_en;
    logic [2:0] mux_sel;
    logic       lock_st;
    logic       fail_st;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    int model_cur = 0;

    always #10 clk = ~clk;

    clk_switch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_src(req_src), .sw_en_set(sw_en_set),
        .ost_done(ost_done), .pll_lock(pll_lock), .src_tick(src_tick),
        .keep_lprc(keep_lprc), .keep_sec(keep_sec), .fail_evt(fail_evt),
        .cur_src(cur_src), .sw_en(sw_en), .osc_en(osc_en), .mux_sel(mux_sel),
        .lock_st(lock_st), .fail_st(fail_st)
    );

    // Oscillators each source needs: bit0 FRC, 1 primary, 2 secondary, 3 LPRC, 4 PLL.
    function automatic logic [4:0] need(input int s);
        case (s)
            0: return 5'b00001;
            1: return 5'b10001;
            2: return 5'b00010;
            3: return 5'b10010;
            4: return 5'b00100;
            5: return 5'b01000;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic [4:0] expect_en(input int s);
        return need(s) | (keep_lprc ? 5'b01000 : 5'b0) | (keep_sec ? 5'b00100 : 5'b0);
    endfunction

    function automatic bit legal(input int from_s, input int to_s);
        if (to_s > 5 || to_s == from_s) return 0;
        if ((from_s == 1 && to_s == 3) || (from_s == 3 && to_s == 1)) return 0;
        return 1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Pulse a request; returns after the second edge (evaluation done).
    task automatic request(input int b);
        @(negedge clk);
        req_src = 3'(b);
        sw_en_set = 1'b1;
        @(negedge clk);
        sw_en_set = 1'b0;
        check("R2 flag set", 32'(sw_en), 1);
        @(negedge clk);
    endtask

    // Drive n ticks of source b with noise on another source in between.
    task automatic ticks(input int b, input int n);
        for (int i = 0; i < n; i++) begin
            src_tick = 6'(1 << b);
            @(negedge clk);
            src_tick = 6'(1 << ((b + 1) % 6));
            @(negedge clk);
            src_tick = 6'd0;
        end
    endtask

    task automatic expect_reject(input int b);
        logic [4:0] en0;
        logic l0, f0;
        en0 = osc_en; l0 = lock_st; f0 = fail_st;
        request(b);
        check(b > 5 || legal(model_cur, b) == 0 && b != model_cur ? "R3 reject flag" : "R2 reject flag", 32'(sw_en), 0);
        check("R2 R3 source kept", 32'(cur_src), 32'(model_cur));
        check("R2 R3 mux kept", 32'(mux_sel), 32'(model_cur));
        check("R2 enables kept", 32'(osc_en), 32'(en0));
        check("R2 status kept", 32'({l0, f0}), 32'({lock_st, fail_st}));
    endtask

    // Full valid switch with ready inputs held high.
    task automatic do_switch(input int b);
        request(b);
        check("R4 fail cleared", 32'(fail_st), 0);
        check("R4 lock cleared", 32'(lock_st), 0);
        check("R5 target enabled", 32'(osc_en & need(b)), 32'(need(b)));
        @(negedge clk);
        @(negedge clk);
        ticks(b, 9);
        check("R7 no commit after nine", 32'({sw_en, cur_src}), 32'({1'b1, 3'(model_cur)}));
        ticks(b, 1);
        model_cur = b;
        check("R8 cur", 32'(cur_src), 32'(b));
        check("R8 mux", 32'(mux_sel), 32'(b));
        check("R8 flag cleared", 32'(sw_en), 0);
        check("R9 enables", 32'(osc_en), 32'(expect_en(b)));
    endtask

    task automatic go_to(input int a);
        if (model_cur == a) return;
        if (!legal(model_cur, a)) do_switch(0);
        do_switch(a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cur", 32'(cur_src), 0);
        check("R1 mux", 32'(mux_sel), 0);
        check("R1 flag", 32'(sw_en), 0);
        check("R1 enables", 32'(osc_en), 32'(5'b00001));
        check("R1 status", 32'({lock_st, fail_st}), 0);

        // Sweep of every start source and request code.
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 8; b++) begin
                go_to(a);
                if (legal(a, b)) do_switch(b);
                else expect_reject(b);
            end
        end

        // R11 / R5 / R10 / R7: start-up timer stall.
        go_to(0);
        ost_done = 1'b0;
        repeat (4) @(negedge clk);
        request(2);
        repeat (20) @(negedge clk);
        ticks(2, 5);
        check("R5 primary on while waiting", 32'(osc_en[1]), 1);
        check("R11 flag held", 32'(sw_en), 1);
        check("R11 cur held", 32'(cur_src), 0);
        @(negedge clk);
        req_src = 3'd5;
        sw_en_set = 1'b1;
        @(negedge clk);
        sw_en_set = 1'b0;
        ost_done = 1'b1;
        repeat (4) @(negedge clk);
        ticks(2, 9);
        check("R7 early ticks ignored", 32'(cur_src), 0);
        ticks(2, 1);
        check("R10 target unchanged", 32'(cur_src), 2);
        model_cur = 2;

        // R6: PLL lock stall from primary to primary with PLL.
        pll_lock = 1'b0;
        repeat (4) @(negedge clk);
        request(3);
        repeat (20) @(negedge clk);
        check("R6 lock low while waiting", 32'(lock_st), 0);
        check("R11 flag held on lock", 32'(sw_en), 1);
        check("R5 PLL on while waiting", 32'(osc_en[4]), 1);
        pll_lock = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 lock seen", 32'(lock_st), 1);
        ticks(3, 10);
        check("R6 commit PLL source", 32'(cur_src), 3);
        model_cur = 3;

        // R4: fail status kept by rejects, cleared by a valid start.
        @(negedge clk);
        fail_evt = 1'b1;
        @(negedge clk);
        fail_evt = 1'b0;
        check("R4 fail set", 32'(fail_st), 1);
        expect_reject(3);
        expect_reject(1);
        check("R3 fail kept", 32'(fail_st), 1);
        do_switch(0);

        // R9: kept oscillators.
        keep_lprc = 1'b1;
        keep_sec = 1'b1;
        do_switch(5);
        do_switch(4);
        do_switch(0);
        keep_lprc = 1'b0;
        keep_sec = 1'b0;
        do_switch(4);
        do_switch(0);
        check("R9 secondary off", 32'(osc_en[2]), 0);
        check("R9 LPRC off", 32'(osc_en[3]), 0);

        finish_run();
    end
endmodule